// File: doc/BRIEF.md
# Decoupled register access bridge

This block lets a host read or write one 32-bit register that sits inside a power-gated domain, without the host first waking that domain itself. The host sees two words: a data word and a command word. The command word holds the target offset, the access direction, a domain selector and a launch bit. Once launched, the bridge raises wake requests to the chosen domain or domains and waits for their acknowledges. It then performs exactly one access on a target-side register bus, returns read data into the data word, and drops the wake requests. Finally it clears the launch bit, which the host polls.

The sequencer has four named states. IDLE waits for a launch. WAKE drives the wake requests and waits for every selected acknowledge. ACCESS holds the target request until the target acknowledges. RELEASE drops the wake requests, pulses the completion output and clears the launch bit. The transitions are IDLE to WAKE on launch, WAKE to ACCESS when every selected acknowledge is high, WAKE to RELEASE on wake timeout, ACCESS to RELEASE on target acknowledge, and RELEASE to IDLE always. A 64-bit value is moved as two commands, at an offset and at that offset plus 4. Because the wake handshake is done in hardware, a single access completes even while the target domain is asleep or changing frequency.

Top module: `decoupled_access_bridge`

## Requirements
- R1: The data word is at host address 0xF00 and the command word at 0xF04; any other address reads 0. The command word reads back as bit 31 launch, bit 30 timeout error, bits 29:28 domain, bit 24 direction, bits TAW-1:0 target offset, and 0 elsewhere. Both words are 0 after reset.
- R2: An access is launched only by a host write to 0xF04 with bit 31 set while the launch bit reads 0. A write with bit 31 clear stores the fields but starts nothing.
- R3: Domain code 0 raises wake_req[0], code 1 raises wake_req[1], code 2 raises wake_req[2], and code 3 raises all three.
- R4: tgt_req is never high unless every raised wake request has its wake_ack high.
- R5: A command with direction 0 (write) makes exactly one target cycle with tgt_we=1, tgt_addr equal to the offset field and tgt_wdata equal to the data word.
- R6: A command with direction 1 (read) makes exactly one target cycle with tgt_we=0, and the returned value is in the data word by the time the launch bit reads 0.
- R7: While the launch bit is 1, host writes to both words are ignored, and the data word keeps its value.
- R8: After an access the wake requests drop. cmd_done is high for one cycle with wake_req at 0, and the launch bit reads 0 from the next cycle on.
- R9: If the selected acknowledges are not all high within WAKE_TMO cycles, no target cycle occurs, bit 30 is set and stays set until reset, and the launch bit still clears.
- R10: Once raised, tgt_req and tgt_addr hold steady until tgt_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 12 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational on host_addr |
| wake_req | output | 3 | Wake requests: bit 0 blitter, bit 1 render, bit 2 media |
| wake_ack | input | 3 | Wake acknowledges, same bit order |
| tgt_req | output | 1 | Target access request |
| tgt_we | output | 1 | Target write enable |
| tgt_addr | output | TAW | Target register offset |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, valid with tgt_ack |
| tgt_ack | input | 1 | Target access complete |
| cmd_done | output | 1 | One-cycle completion pulse |

## Verification
The bench gives each domain an acknowledge latency of its own, so the "all domains" selector is tested with one slow domain. A bridge that checked only one acknowledge would then reach the target early. It writes both words while a slow wake is pending; a bridge that did not block them would send the wrong data or the wrong offset. It stores a command without the launch bit and checks that no wake or target traffic follows, and it holds one acknowledge low to force a timeout. A bridge that hung there or touched the target would be caught. Read pairs at adjacent offsets check the two-command 64-bit pattern, and random commands check the domain mapping and data paths.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam logic [11:0] ADDR_DATA = 12'hF00;
    localparam logic [11:0] ADDR_CTRL = 12'hF04;
    localparam int          NDOM      = 3;
    localparam int          BIT_GO    = 31;
    localparam int          BIT_ERR   = 30;
    localparam int          BIT_OP    = 24;

    typedef enum logic [1:0] {
        DOM_BLT = 2'd0,
        DOM_RND = 2'd1,
        DOM_MED = 2'd2,
        DOM_ALL = 2'd3
    } dom_e;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAKE,
        S_ACCESS,
        S_RELEASE
    } state_e;

    function automatic logic [NDOM-1:0] dom_mask(input dom_e d);
        logic [NDOM-1:0] m;
        unique case (d)
            DOM_BLT: m = 3'b001;
            DOM_RND: m = 3'b010;
            DOM_MED: m = 3'b100;
            DOM_ALL: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dcb_window.sv
module dcb_window
    import dcb_pkg::*;
#(
    parameter int TAW = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [11:0]     host_addr,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    input  logic            finish,
    input  logic            cap_rd,
    input  logic [31:0]     rd_data,
    input  logic            set_err,
    output logic            launch,
    output dom_e            cmd_dom,
    output op_e             cmd_op,
    output logic [TAW-1:0]  cmd_ofs,
    output logic [31:0]     data_word
);

    localparam logic [31:0] OFS_MASK = (32'h1 << TAW) - 32'h1;
    localparam logic [31:0] WR_MASK  = OFS_MASK | 32'h3000_0000 | (32'h1 << BIT_OP);
    localparam logic [31:0] TOP_MASK = 32'hC000_0000;

    logic [31:0] ctrl_q;
    logic [31:0] data_q;
    logic        go_q;
    logic        err_q;
    logic        wr_ctrl;
    logic        wr_data;
    logic [31:0] ctrl_view;

    // host writes are accepted only while no access is pending
    assign wr_ctrl = host_wr && (host_addr == ADDR_CTRL) && !go_q;
    assign wr_data = host_wr && (host_addr == ADDR_DATA) && !go_q;
    assign launch  = wr_ctrl && host_wdata[BIT_GO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
            go_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= host_wdata & WR_MASK;
            end
            if (wr_data) begin
                data_q <= host_wdata;
            end else if (cap_rd) begin
                data_q <= rd_data;
            end
            if (launch) begin
                go_q <= 1'b1;
            end else if (finish) begin
                go_q <= 1'b0;
            end
            if (set_err) begin
                err_q <= 1'b1;
            end
        end
    end

    assign cmd_dom   = dom_e'(ctrl_q[29:28]);
    assign cmd_op    = op_e'(ctrl_q[BIT_OP]);
    assign cmd_ofs   = ctrl_q[TAW-1:0];
    assign data_word = data_q;

    always_comb begin
        ctrl_view          = ctrl_q & ~TOP_MASK;
        ctrl_view[BIT_GO]  = go_q;
        ctrl_view[BIT_ERR] = err_q;
    end

    always_comb begin
        unique case (host_addr)
            ADDR_DATA: host_rdata = data_q;
            ADDR_CTRL: host_rdata = ctrl_view;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dcb_wake.sv
module dcb_wake
    import dcb_pkg::*;
#(
    parameter int WAKE_TMO = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_en,
    input  dom_e            dom,
    input  logic [NDOM-1:0] wake_ack,
    output logic [NDOM-1:0] wake_req,
    output logic            all_up,
    output logic            expired
);

    localparam int CW = $clog2(WAKE_TMO + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_TMO - 1);

    logic [NDOM-1:0] mask;
    logic [CW-1:0]   cnt_q;

    assign mask     = dom_mask(dom);
    assign wake_req = req_en ? mask : '0;
    assign all_up   = &(wake_ack | ~mask);
    assign expired  = req_en && !all_up && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!req_en || all_up) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/dcb_seq.sv
module dcb_seq
    import dcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic all_up,
    input  logic expired,
    input  logic tgt_ack,
    input  op_e  op,
    output logic req_en,
    output logic tgt_req,
    output logic finish,
    output logic cap_rd,
    output logic set_err
);

    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (launch) state_d = S_WAKE;
            end
            S_WAKE: begin
                if (all_up)       state_d = S_ACCESS;
                else if (expired) state_d = S_RELEASE;
            end
            S_ACCESS: begin
                if (tgt_ack) state_d = S_RELEASE;
            end
            S_RELEASE: begin
                state_d = S_IDLE;
            end
        endcase
    end

    always_comb begin
        req_en  = 1'b0;
        tgt_req = 1'b0;
        finish  = 1'b0;
        cap_rd  = 1'b0;
        set_err = 1'b0;
        unique case (state_q)
            S_IDLE: begin
            end
            S_WAKE: begin
                req_en  = 1'b1;
                set_err = !all_up && expired;
            end
            S_ACCESS: begin
                req_en  = 1'b1;
                tgt_req = 1'b1;
                cap_rd  = tgt_ack && (op == OP_RD);
            end
            S_RELEASE: begin
                finish = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/decoupled_access_bridge.sv
module decoupled_access_bridge
    import dcb_pkg::*;
#(
    parameter int TAW      = 22,
    parameter int WAKE_TMO = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [11:0]     host_addr,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    output logic [2:0]      wake_req,
    input  logic [2:0]      wake_ack,
    output logic            tgt_req,
    output logic            tgt_we,
    output logic [TAW-1:0]  tgt_addr,
    output logic [31:0]     tgt_wdata,
    input  logic [31:0]     tgt_rdata,
    input  logic            tgt_ack,
    output logic            cmd_done
);

    logic           launch;
    logic           finish;
    logic           cap_rd;
    logic           set_err;
    logic           req_en;
    logic           all_up;
    logic           expired;
    dom_e           cmd_dom;
    op_e            cmd_op;
    logic [TAW-1:0] cmd_ofs;
    logic [31:0]    data_word;

    dcb_window #(.TAW(TAW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .finish     (finish),
        .cap_rd     (cap_rd),
        .rd_data    (tgt_rdata),
        .set_err    (set_err),
        .launch     (launch),
        .cmd_dom    (cmd_dom),
        .cmd_op     (cmd_op),
        .cmd_ofs    (cmd_ofs),
        .data_word  (data_word)
    );

    dcb_wake #(.WAKE_TMO(WAKE_TMO)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (req_en),
        .dom      (cmd_dom),
        .wake_ack (wake_ack),
        .wake_req (wake_req),
        .all_up   (all_up),
        .expired  (expired)
    );

    dcb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .all_up  (all_up),
        .expired (expired),
        .tgt_ack (tgt_ack),
        .op      (cmd_op),
        .req_en  (req_en),
        .tgt_req (tgt_req),
        .finish  (finish),
        .cap_rd  (cap_rd),
        .set_err (set_err)
    );

    assign tgt_we    = (cmd_op == OP_WR);
    assign tgt_addr  = cmd_ofs;
    assign tgt_wdata = data_word;
    assign cmd_done  = finish;

endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
    parameter int TAW      = 22,
    parameter int WAKE_TMO = 64
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     wake_req,
    input logic [2:0]     wake_ack,
    input logic           tgt_req,
    input logic           tgt_ack,
    input logic [TAW-1:0] tgt_addr,
    input logic           cmd_done
);

    int unsigned wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= 0;
        end else if ((wake_req != 3'b000) && !tgt_req) begin
            wait_cnt <= wait_cnt + 1;
        end else begin
            wait_cnt <= 0;
        end
    end

    a_r4_ack_before_access: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> ((wake_req != 3'b000) && ((wake_ack & wake_req) == wake_req)));

    a_r3_domain_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_req) || (wake_req == 3'b111));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r8_asleep_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> ((wake_req == 3'b000) && !tgt_req));

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr)));

    a_r9_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_req != 3'b000) && !tgt_req) |-> (wait_cnt < WAKE_TMO));

endmodule

bind decoupled_access_bridge dcb_checker #(.TAW(TAW), .WAKE_TMO(WAKE_TMO)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake_req (wake_req),
    .wake_ack (wake_ack),
    .tgt_req  (tgt_req),
    .tgt_ack  (tgt_ack),
    .tgt_addr (tgt_addr),
    .cmd_done (cmd_done)
);

// File: tb/sim_decoupled_access_bridge.sv
module sim_decoupled_access_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int TAW        = 22;
    localparam int TMO        = 24;
    localparam logic [11:0] A_DATA = 12'hF00;
    localparam logic [11:0] A_CTRL = 12'hF04;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_wr = 1'b0;
    logic [11:0]    host_addr = '0;
    logic [31:0]    host_wdata = '0;
    logic [31:0]    host_rdata;
    logic [2:0]     wake_req;
    logic [2:0]     wake_ack;
    logic           tgt_req;
    logic           tgt_we;
    logic [TAW-1:0] tgt_addr;
    logic [31:0]    tgt_wdata;
    logic [31:0]    tgt_rdata;
    logic           tgt_ack;
    logic           cmd_done;

    int nchk = 0;
    int nfail = 0;

    decoupled_access_bridge #(.TAW(TAW), .WAKE_TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .wake_req(wake_req),
        .wake_ack(wake_ack), .tgt_req(tgt_req), .tgt_we(tgt_we),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .tgt_ack(tgt_ack), .cmd_done(cmd_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // domain and target models
    int          lat [3];
    logic [2:0]  dead = 3'b000;
    int          wcnt [3];
    int          tdel = 0;
    int          tcnt = 0;
    logic [31:0] mem [64];
    logic [31:0] exp_mem [64];
    int          n_acc = 0;
    int          n_done = 0;
    int          n_viol = 0;
    logic            last_we;
    logic [TAW-1:0]  last_addr;
    logic [31:0]     last_wdata;
    logic [2:0]      last_wreq;

    function automatic logic [31:0] seed_val(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0101_0103);
    endfunction

    function automatic logic [2:0] exp_mask(input logic [1:0] d);
        case (d)
            2'd0:    return 3'b001;
            2'd1:    return 3'b010;
            2'd2:    return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [31:0] cmd_word(input logic go, input logic [1:0] d,
                                             input logic op, input logic [TAW-1:0] ofs);
        logic [31:0] w;
        w = 32'(ofs);
        w[24] = op;
        w[29:28] = d;
        w[31] = go;
        return w;
    endfunction

    always_comb begin
        for (int i = 0; i < 3; i++)
            wake_ack[i] = wake_req[i] && (wcnt[i] >= lat[i]) && !dead[i];
    end

    assign tgt_ack   = tgt_req && (tcnt >= tdel);
    assign tgt_rdata = mem[tgt_addr[7:2]];

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++)
            wcnt[i] <= wake_req[i] ? wcnt[i] + 1 : 0;
        tcnt <= (tgt_req && !tgt_ack) ? tcnt + 1 : 0;
        if (tgt_req && ((wake_ack & wake_req) != wake_req)) n_viol <= n_viol + 1;
        if (cmd_done) n_done <= n_done + 1;
        if (tgt_req && tgt_ack) begin
            n_acc      <= n_acc + 1;
            last_we    <= tgt_we;
            last_addr  <= tgt_addr;
            last_wdata <= tgt_wdata;
            last_wreq  <= wake_req;
            if (tgt_we) mem[tgt_addr[7:2]] <= tgt_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] c);
        for (int k = 0; k < 400; k++) begin
            hread(A_CTRL, c);
            if (!c[31]) break;
        end
    endtask

    task automatic run_cmd(input logic op, input logic [1:0] d, input logic [TAW-1:0] ofs,
                           input logic [31:0] wd, output logic [31:0] rd);
        logic [31:0] c;
        if (!op) hwrite(A_DATA, wd);
        hwrite(A_CTRL, cmd_word(1'b0, d, op, ofs));
        hwrite(A_CTRL, cmd_word(1'b1, d, op, ofs));
        wait_idle(c);
        rd = '0;
        if (op) hread(A_DATA, rd);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, rd, c;
        int acc0, done0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            mem[i] = seed_val(i);
            exp_mem[i] = seed_val(i);
        end
        for (int i = 0; i < 3; i++) begin
            lat[i] = 1;
            wcnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R1, R8)
        hread(A_DATA, v); chk("R1 data reset", v, 32'h0);
        hread(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
        chk("R8 no wake after reset", 32'(wake_req), 32'h0);
        hread(12'h100, v); chk("R1 unmapped reads zero", v, 32'h0);

        // fields stored without launch (R2, R1 layout)
        acc0 = n_acc;
        hwrite(A_CTRL, cmd_word(1'b0, 2'd2, 1'b1, 22'h2A_BC40));
        repeat (8) @(negedge clk);
        chk("R2 no wake without go", 32'(wake_req), 32'h0);
        chk("R2 no access without go", 32'(n_acc), 32'(acc0));
        hread(A_CTRL, v); chk("R1 ctrl layout", v, 32'h212A_BC40);

        // random commands (R3, R5, R6, R8)
        for (int n = 0; n < 28; n++) begin
            logic op; logic [1:0] d; logic [5:0] idx; logic [TAW-1:0] ofs; logic [31:0] wd;
            op  = 1'($urandom);
            d   = 2'($urandom);
            idx = 6'($urandom);
            ofs = {14'($urandom), idx, 2'b00};
            wd  = $urandom;
            for (int i = 0; i < 3; i++) lat[i] = $urandom_range(0, 6);
            tdel = $urandom_range(0, 2);
            acc0 = n_acc; done0 = n_done;
            run_cmd(op, d, ofs, wd, rd);
            chk("R5 one access per command", 32'(n_acc - acc0), 32'd1);
            chk("R5 target offset", 32'(last_addr), 32'(ofs));
            chk("R5 direction", 32'(last_we), 32'(!op));
            chk("R3 domain mapping", 32'(last_wreq), 32'(exp_mask(d)));
            if (op) begin
                chk("R6 read data", rd, exp_mem[idx]);
            end else begin
                chk("R5 write data", last_wdata, wd);
                exp_mem[idx] = wd;
            end
            chk("R8 domains asleep after", 32'(wake_req), 32'h0);
            chk("R8 one done pulse", 32'(n_done - done0), 32'd1);
        end

        // all domains with one slow acknowledge (R3, R4)
        lat[0] = 1; lat[1] = 0; lat[2] = 14; tdel = 0;
        run_cmd(1'b1, 2'd3, 22'h0000_10, 32'h0, rd);
        chk("R3 all domains raised", 32'(last_wreq), 32'h7);
        chk("R6 read under all", rd, exp_mem[4]);

        // writes ignored while busy (R7)
        for (int i = 0; i < 3; i++) lat[i] = 12;
        acc0 = n_acc;
        hwrite(A_DATA, 32'hCAFE_0001);
        hwrite(A_CTRL, cmd_word(1'b0, 2'd0, 1'b0, 22'h0000_20));
        hwrite(A_CTRL, cmd_word(1'b1, 2'd0, 1'b0, 22'h0000_20));
        hwrite(A_DATA, 32'hDEAD_BEEF);
        hwrite(A_CTRL, cmd_word(1'b1, 2'd1, 1'b1, 22'h0000_3C));
        hread(A_DATA, v); chk("R7 data word kept", v, 32'hCAFE_0001);
        hread(A_CTRL, v); chk("R7 ctrl kept", v, cmd_word(1'b1, 2'd0, 1'b0, 22'h0000_20));
        wait_idle(c);
        chk("R7 single access", 32'(n_acc - acc0), 32'd1);
        chk("R7 original offset", 32'(last_addr), 32'h20);
        chk("R7 original data", last_wdata, 32'hCAFE_0001);
        exp_mem[8] = 32'hCAFE_0001;

        // 64-bit value as two reads (R6)
        for (int i = 0; i < 3; i++) lat[i] = 2;
        run_cmd(1'b1, 2'd1, 22'h0000_20, 32'h0, rd);
        chk("R6 low word", rd, exp_mem[8]);
        run_cmd(1'b1, 2'd1, 22'h0000_24, 32'h0, rd);
        chk("R6 high word", rd, exp_mem[9]);

        // wake timeout (R9)
        hread(A_CTRL, v); chk("R9 no error before", 32'(v[30]), 32'h0);
        dead = 3'b010;
        acc0 = n_acc;
        hwrite(A_CTRL, cmd_word(1'b0, 2'd1, 1'b1, 22'h0000_04));
        hwrite(A_CTRL, cmd_word(1'b1, 2'd1, 1'b1, 22'h0000_04));
        wait_idle(c);
        chk("R9 go clears on timeout", 32'(c[31]), 32'h0);
        chk("R9 error set", 32'(c[30]), 32'h1);
        chk("R9 no target access", 32'(n_acc - acc0), 32'h0);
        chk("R9 domains released", 32'(wake_req), 32'h0);
        dead = 3'b000;
        run_cmd(1'b1, 2'd2, 22'h0000_08, 32'h0, rd);
        chk("R9 later access works", rd, exp_mem[2]);
        hread(A_CTRL, v); chk("R9 error sticky", 32'(v[30]), 32'h1);

        chk("R4 no access before ack", 32'(n_viol), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule